// File: doc/BRIEF.md
# LCD Panel Timing Generator

This block derives every timing strobe an LCD panel needs from one core clock: a dot clock, a launch strobe that marks the core cycle in which pixel data should change, a data-enable strobe, a line-sync pulse and a frame-sync pulse. The dot period is set by a programmable divider, can be forced to one core cycle by a bypass control, and is never shorter than a floor that depends on panel type, scan mode and data-bus width. The dot clock is a registered square wave. It is not a gated clock.

Each line has three segments: a pixel segment in which data-enable is high, a porch segment, and a sync segment in which the line-sync pulse is high. Each segment lasts a programmable number of dot periods. A frame is a programmable number of lines, and the frame-sync pulse covers all of the first line. In free-running mode the dot clock toggles without a break. In gated mode a pixel-segment dot period starts only when the pixel pipeline reports data available. All settings are captured in a shadow register at each frame boundary, so a frame never mixes two timings.

A sequencer state machine has four states: `ST_IDLE`, `ST_PIXELS`, `ST_PORCH` and `ST_SYNC`. Its transitions are:
- IDLE→PIXELS, one cycle after reset, with the first configuration load.
- PIXELS→PORCH, when the last pixel period ends.
- PORCH→SYNC, when the last porch period ends.
- SYNC→PIXELS, when the last sync period ends. This is the next line, or on the last line the frame boundary, where the configuration is reloaded.

Top module: `lcd_timing_gen`

## Requirements
- R1: While `rst_n` is low, `dot_clk`, `launch`, `den`, `hsync` and `vsync` are all 0.
- R2: When the bypass is off, `cfg_div` is non-zero and 2×`cfg_div` is at least the floor, the dot period P is 2×`cfg_div` core cycles. `dot_clk` is high for the first P/2 cycles of each period and low for the rest.
- R3: With `cfg_bypass`=1 the divider is ignored and the unclamped period is one core cycle. At a period of 1, `dot_clk` stays low and `launch` pulses every core cycle.
- R4: The period floor in core cycles, by `cfg_panel` (0 = TFT, 1 = monochrome STN, 2 = colour STN, 3 = treated as TFT) and bus width `cfg_bus` (0 = 4 bit, 1 = 8 bit, 2 = 16 bit), is:
  - TFT: 1.
  - Monochrome single scan: 4 at 4 bit, 8 otherwise.
  - Monochrome dual scan (`cfg_dual`=1): 16 at 16 bit, 8 otherwise.
  - Colour single scan: 2.
  - Colour dual scan: 6 at 16 bit, 4 otherwise.
  A shorter period is raised to the floor, and `cfg_div`=0 gives the floor.
- R5: With `cfg_launch_rise`=0, `launch` is high in the first low cycle of `dot_clk` in each period, which is the falling edge. With `cfg_launch_rise`=1, `launch` is high in the first high cycle, which is the rising edge. There is one launch per dot period.
- R6: With `cfg_gated`=1, a pixel-segment period starts only if `pix_avail` is high in the cycle where the previous period ends or the clock is idle. A period that has started always completes. While starts are refused, `dot_clk`, `launch` and `den` stay low. Porch and sync periods run regardless of `pix_avail`.
- R7: `den` is high for exactly the `cfg_px`+1 pixel periods of each line and is never high together with `hsync`.
- R8: After the last pixel period there are `cfg_porch`+1 dot periods before `hsync` rises.
- R9: `hsync` is high for `cfg_sync_w`+1 dot periods per line.
- R10: A frame has `cfg_lines`+1 lines. `vsync` is high for the whole first line and falls right after that line's `hsync`.
- R11: Configuration inputs are sampled only at the frame boundary. A change made during a frame does not alter that frame.
- R12: In free-running mode (`cfg_gated`=0) dot periods follow back to back, so launches are exactly P cycles apart and `pix_avail` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_div | input | DIV_W | Divider value; period 2×value |
| cfg_bypass | input | 1 | Force a one-cycle unclamped period |
| cfg_launch_rise | input | 1 | 1: data launched at rising dot edge |
| cfg_gated | input | 1 | 1: pixel periods wait for data |
| cfg_panel | input | 2 | Panel type code |
| cfg_dual | input | 1 | Dual-scan STN |
| cfg_bus | input | 2 | Data-bus width code |
| cfg_px | input | PX_W | Pixels per line minus one |
| cfg_porch | input | DLY_W | Porch periods minus one |
| cfg_sync_w | input | PW_W | Line-sync periods minus one |
| cfg_lines | input | LN_W | Lines per frame minus one |
| pix_avail | input | 1 | Pixel pipeline has data |
| dot_clk | output | 1 | Registered dot clock |
| launch | output | 1 | Data-change strobe |
| den | output | 1 | Data enable |
| hsync | output | 1 | Line sync |
| vsync | output | 1 | Frame sync |

## Verification
The frame-boundary reload of the shadow configuration and the start of the next dot period happen on the same edge. The new period is counted against the new divider while the period that just ended was timed with the old one. The bench provokes this on every frame: at each frame-sync rise it writes the configuration for the next frame, and it sweeps divider, bypass, panel, scan and bus settings, so successive periods differ in length. Each frame is judged by measuring its length, its strobe counts and its launch spacing and comparing them with values computed from that frame's own settings. In gated mode the same edge also carries the pixel-available decision, and a random availability pattern exercises it.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;

    typedef enum logic [1:0] {
        PNL_TFT   = 2'd0,
        PNL_MONO  = 2'd1,
        PNL_COLOR = 2'd2,
        PNL_RSVD  = 2'd3
    } panel_e;

    typedef enum logic [1:0] {
        BUS_4    = 2'd0,
        BUS_8    = 2'd1,
        BUS_16   = 2'd2,
        BUS_RSVD = 2'd3
    } bus_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PIXELS = 2'd1,
        ST_PORCH  = 2'd2,
        ST_SYNC   = 2'd3
    } seq_state_e;

    localparam int FLOOR_W = 5;

    // Shortest legal dot period in core cycles for a panel arrangement.
    function automatic logic [FLOOR_W-1:0] dot_floor(panel_e pnl, logic dual, bus_e bus);
        logic [FLOOR_W-1:0] f;
        case (pnl)
            PNL_MONO:  f = dual ? ((bus == BUS_16) ? 5'd16 : 5'd8)
                                : ((bus == BUS_4)  ? 5'd4  : 5'd8);
            PNL_COLOR: f = dual ? ((bus == BUS_16) ? 5'd6  : 5'd4) : 5'd2;
            default:   f = 5'd1;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/lcd_tg_period.sv
module lcd_tg_period
    import lcd_tg_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  panel_e           sh_panel,
    input  logic             sh_dual,
    input  bus_e             sh_bus,
    input  logic             sh_bypass,
    input  logic [DIV_W-1:0] sh_div,
    output logic [DIV_W:0]   period
);
    localparam int PER_W = DIV_W + 1;

    logic [PER_W-1:0] base;
    logic [PER_W-1:0] floor_v;

    always_comb begin
        floor_v = PER_W'(dot_floor(sh_panel, sh_dual, sh_bus));
        if (sh_bypass)
            base = PER_W'(1);
        else
            base = {sh_div, 1'b0};          // zero divider gives 0, lifted below
        period = (base < floor_v) ? floor_v : base;
    end
endmodule

// File: rtl/lcd_tg_dotdiv.sv
module lcd_tg_dotdiv #(
    parameter int PER_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PER_W-1:0] period,
    input  logic             go,
    input  logic             rise_sel,
    output logic             period_end,
    output logic             running,
    output logic             dot_clk_o,
    output logic             launch_o
);
    logic [PER_W-1:0] ph;
    logic             run;
    logic [PER_W-1:0] half;
    logic             start;

    assign half       = period >> 1;
    assign period_end = run && (ph == period - PER_W'(1));
    assign start      = go && (!run || period_end);
    assign running    = run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run       <= 1'b0;
            ph        <= '0;
            dot_clk_o <= 1'b0;
            launch_o  <= 1'b0;
        end else begin
            if (start) begin
                run <= 1'b1;
                ph  <= '0;
            end else if (period_end) begin
                run <= 1'b0;
            end else if (run) begin
                ph <= ph + PER_W'(1);
            end
            dot_clk_o <= run && (ph < half);
            launch_o  <= run && (ph == (rise_sel ? PER_W'(0) : half));
        end
    end

    assert_phase_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (ph < period));

endmodule

// File: rtl/lcd_tg_seq.sv
module lcd_tg_seq
    import lcd_tg_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int PX_W  = 10,
    parameter int DLY_W = 6,
    parameter int PW_W  = 6,
    parameter int LN_W  = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             cfg_bypass,
    input  logic             cfg_rise,
    input  logic             cfg_gated,
    input  panel_e           cfg_panel,
    input  logic             cfg_dual,
    input  bus_e             cfg_bus,
    input  logic [PX_W-1:0]  cfg_px,
    input  logic [DLY_W-1:0] cfg_porch,
    input  logic [PW_W-1:0]  cfg_sync_w,
    input  logic [LN_W-1:0]  cfg_lines,
    input  logic             pix_avail,
    input  logic             period_end,
    input  logic             running,
    output panel_e           sh_panel,
    output logic             sh_dual,
    output bus_e             sh_bus,
    output logic             sh_bypass,
    output logic [DIV_W-1:0] sh_div,
    output logic             sh_rise,
    output logic             go,
    output logic             den_o,
    output logic             hsync_o,
    output logic             vsync_o
);
    localparam int MAX_A = (PX_W > DLY_W) ? PX_W : DLY_W;
    localparam int CNT_W = (MAX_A > PW_W) ? MAX_A : PW_W;

    seq_state_e       state, nxt;
    logic [CNT_W-1:0] cnt, cnt_lim;
    logic [LN_W-1:0]  line;
    logic             sh_gated;
    logic [PX_W-1:0]  sh_px;
    logic [DLY_W-1:0] sh_porch;
    logic [PW_W-1:0]  sh_sync_w;
    logic [LN_W-1:0]  sh_lines;
    logic             seg_done, frame_done, load, gated_eff;

    always_comb begin
        unique case (state)
            ST_PIXELS: cnt_lim = CNT_W'(sh_px);
            ST_PORCH:  cnt_lim = CNT_W'(sh_porch);
            ST_SYNC:   cnt_lim = CNT_W'(sh_sync_w);
            ST_IDLE:   cnt_lim = '0;
        endcase
        seg_done   = period_end && (cnt == cnt_lim);
        frame_done = (state == ST_SYNC) && seg_done && (line == sh_lines);
        load       = (state == ST_IDLE) || frame_done;
        gated_eff  = load ? cfg_gated : sh_gated;
    end

    always_comb begin
        unique case (state)
            ST_IDLE:   nxt = ST_PIXELS;
            ST_PIXELS: nxt = seg_done ? ST_PORCH  : ST_PIXELS;
            ST_PORCH:  nxt = seg_done ? ST_SYNC   : ST_PORCH;
            ST_SYNC:   nxt = seg_done ? ST_PIXELS : ST_SYNC;
        endcase
        // Start decision looks at the state the new period will belong to.
        if (nxt == ST_PIXELS)
            go = !gated_eff || pix_avail;
        else
            go = (nxt != ST_IDLE);
    end

    // State register, segment and line counters, shadow configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            line      <= '0;
            sh_panel  <= PNL_TFT;
            sh_dual   <= 1'b0;
            sh_bus    <= BUS_4;
            sh_bypass <= 1'b0;
            sh_div    <= '0;
            sh_rise   <= 1'b0;
            sh_gated  <= 1'b0;
            sh_px     <= '0;
            sh_porch  <= '0;
            sh_sync_w <= '0;
            sh_lines  <= '0;
        end else begin
            state <= nxt;
            if (seg_done || (state != nxt))
                cnt <= '0;
            else if (period_end)
                cnt <= cnt + CNT_W'(1);
            if (load)
                line <= '0;
            else if ((state == ST_SYNC) && seg_done)
                line <= line + LN_W'(1);
            if (load) begin
                sh_panel  <= cfg_panel;
                sh_dual   <= cfg_dual;
                sh_bus    <= cfg_bus;
                sh_bypass <= cfg_bypass;
                sh_div    <= cfg_div;
                sh_rise   <= cfg_rise;
                sh_gated  <= cfg_gated;
                sh_px     <= cfg_px;
                sh_porch  <= cfg_porch;
                sh_sync_w <= cfg_sync_w;
                sh_lines  <= cfg_lines;
            end
        end
    end

    // Output register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            den_o   <= 1'b0;
            hsync_o <= 1'b0;
            vsync_o <= 1'b0;
        end else begin
            den_o   <= (state == ST_PIXELS) && running;
            hsync_o <= (state == ST_SYNC);
            vsync_o <= (state != ST_IDLE) && (line == '0);
        end
    end

    assert_den_needs_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(den_o) && $past(gated_eff, 2)) |-> $past(pix_avail, 2));

    assert_den_hsync_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(den_o && hsync_o));

    assert_vsync_ends_after_sync_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vsync_o) |-> $past(hsync_o));

endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
    import lcd_tg_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int PX_W  = 10,
    parameter int DLY_W = 6,
    parameter int PW_W  = 6,
    parameter int LN_W  = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             cfg_bypass,
    input  logic             cfg_launch_rise,
    input  logic             cfg_gated,
    input  logic [1:0]       cfg_panel,
    input  logic             cfg_dual,
    input  logic [1:0]       cfg_bus,
    input  logic [PX_W-1:0]  cfg_px,
    input  logic [DLY_W-1:0] cfg_porch,
    input  logic [PW_W-1:0]  cfg_sync_w,
    input  logic [LN_W-1:0]  cfg_lines,
    input  logic             pix_avail,
    output logic             dot_clk,
    output logic             launch,
    output logic             den,
    output logic             hsync,
    output logic             vsync
);
    localparam int PER_W = DIV_W + 1;

    panel_e           sh_panel;
    bus_e             sh_bus;
    logic             sh_dual, sh_bypass, sh_rise;
    logic [DIV_W-1:0] sh_div;
    logic [PER_W-1:0] period;
    logic             go, period_end, running;

    lcd_tg_seq #(
        .DIV_W(DIV_W), .PX_W(PX_W), .DLY_W(DLY_W), .PW_W(PW_W), .LN_W(LN_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_div    (cfg_div),
        .cfg_bypass (cfg_bypass),
        .cfg_rise   (cfg_launch_rise),
        .cfg_gated  (cfg_gated),
        .cfg_panel  (panel_e'(cfg_panel)),
        .cfg_dual   (cfg_dual),
        .cfg_bus    (bus_e'(cfg_bus)),
        .cfg_px     (cfg_px),
        .cfg_porch  (cfg_porch),
        .cfg_sync_w (cfg_sync_w),
        .cfg_lines  (cfg_lines),
        .pix_avail  (pix_avail),
        .period_end (period_end),
        .running    (running),
        .sh_panel   (sh_panel),
        .sh_dual    (sh_dual),
        .sh_bus     (sh_bus),
        .sh_bypass  (sh_bypass),
        .sh_div     (sh_div),
        .sh_rise    (sh_rise),
        .go         (go),
        .den_o      (den),
        .hsync_o    (hsync),
        .vsync_o    (vsync)
    );

    lcd_tg_period #(.DIV_W(DIV_W)) u_period (
        .sh_panel  (sh_panel),
        .sh_dual   (sh_dual),
        .sh_bus    (sh_bus),
        .sh_bypass (sh_bypass),
        .sh_div    (sh_div),
        .period    (period)
    );

    lcd_tg_dotdiv #(.PER_W(PER_W)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .period     (period),
        .go         (go),
        .rise_sel   (sh_rise),
        .period_end (period_end),
        .running    (running),
        .dot_clk_o  (dot_clk),
        .launch_o   (launch)
    );

    assert_fall_launch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && !$past(sh_rise) && ($past(period) >= PER_W'(2))) |-> $fell(dot_clk));

    assert_rise_launch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && $past(sh_rise) && ($past(period) >= PER_W'(2))) |-> $rose(dot_clk));

endmodule

// File: tb/lcd_timing_gen_bench.sv
module lcd_timing_gen_bench;
    localparam int DIV_W = 8, PX_W = 4, DLY_W = 3, PW_W = 3, LN_W = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [DIV_W-1:0] cfg_div = '0;
    logic cfg_bypass = 0, cfg_launch_rise = 0, cfg_gated = 0, cfg_dual = 0;
    logic [1:0] cfg_panel = '0, cfg_bus = '0;
    logic [PX_W-1:0] cfg_px = '0;
    logic [DLY_W-1:0] cfg_porch = '0;
    logic [PW_W-1:0] cfg_sync_w = '0;
    logic [LN_W-1:0] cfg_lines = '0;
    logic pix_avail = 1'b0;
    logic dot_clk, launch, den, hsync, vsync;

    always #10 clk = ~clk;

    lcd_timing_gen #(.DIV_W(DIV_W), .PX_W(PX_W), .DLY_W(DLY_W), .PW_W(PW_W), .LN_W(LN_W)) u_lcd_timing_gen (
        .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_bypass(cfg_bypass),
        .cfg_launch_rise(cfg_launch_rise), .cfg_gated(cfg_gated), .cfg_panel(cfg_panel),
        .cfg_dual(cfg_dual), .cfg_bus(cfg_bus), .cfg_px(cfg_px), .cfg_porch(cfg_porch),
        .cfg_sync_w(cfg_sync_w), .cfg_lines(cfg_lines), .pix_avail(pix_avail),
        .dot_clk(dot_clk), .launch(launch), .den(den), .hsync(hsync), .vsync(vsync));

    int n_checks = 0, n_err = 0;
    bit done = 0;
    bit avail_rand = 1;
    logic [7:0] lfsr = 8'h5a;
    logic pv_vs = 0, pd = 0, phs = 0;

    int cur_pan, cur_dual, cur_bus, cur_byp, cur_div, cur_rise, cur_gated, cur_px, cur_dly, cur_pw, cur_ln;
    int m_cyc, m_den, m_hs, m_vs, m_launch, m_dhi, m_align, m_min, m_max, m_gap, m_last_l, m_last_d;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int exp_floor(int pan, int dual, int bus);
        if (pan == 1) return dual ? ((bus == 2) ? 16 : 8) : ((bus == 0) ? 4 : 8);
        if (pan == 2) return dual ? ((bus == 2) ? 6 : 4) : 2;
        return 1;
    endfunction

    function automatic int exp_p(int pan, int dual, int bus, int byp, int div);
        int mn = exp_floor(pan, dual, bus);
        int base = byp ? 1 : 2 * div;
        return (base < mn) ? mn : base;
    endfunction

    task automatic sample_step();
        pv_vs = vsync; pd = dot_clk; phs = hsync;
        @(negedge clk);
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        if (avail_rand) pix_avail = (lfsr[2:0] != 3'd0);
    endtask

    task automatic wait_rise();
        for (int k = 0; k < 30000; k++) begin
            sample_step();
            if (vsync && !pv_vs) break;
        end
    endtask

    task automatic apply(input int pan, dual, bus, byp, div, rise, gated, px, dly, pw, ln);
        cfg_panel = 2'(pan); cfg_dual = dual[0]; cfg_bus = 2'(bus); cfg_bypass = byp[0];
        cfg_div = DIV_W'(div); cfg_launch_rise = rise[0]; cfg_gated = gated[0];
        cfg_px = PX_W'(px); cfg_porch = DLY_W'(dly); cfg_sync_w = PW_W'(pw); cfg_lines = LN_W'(ln);
    endtask

    task automatic measure();
        int c = 0;
        m_den = 0; m_hs = 0; m_vs = 0; m_launch = 0; m_dhi = 0; m_align = 0;
        m_min = 1 << 30; m_max = 0; m_gap = -1; m_last_l = -1; m_last_d = -1;
        forever begin
            if (den) begin m_den++; m_last_d = c; end
            if (hsync) begin
                m_hs++;
                if (m_gap < 0 && !phs) m_gap = c - m_last_d - 1;
            end
            if (vsync) m_vs++;
            if (dot_clk) m_dhi++;
            if (launch) begin
                m_launch++;
                if (cfg_rise_cur() ? (dot_clk && !pd) : (!dot_clk && (pd || exp_p(cur_pan, cur_dual, cur_bus, cur_byp, cur_div) == 1)))
                    m_align++;
                if (m_last_l >= 0) begin
                    if (c - m_last_l < m_min) m_min = c - m_last_l;
                    if (c - m_last_l > m_max) m_max = c - m_last_l;
                end
                m_last_l = c;
            end
            sample_step();
            c++;
            if ((vsync && !pv_vs) || c > 30000) break;
        end
        m_cyc = c;
    endtask

    function automatic bit cfg_rise_cur();
        return (cur_rise != 0) && (exp_p(cur_pan, cur_dual, cur_bus, cur_byp, cur_div) > 1);
    endfunction

    task automatic check_frame();
        int p = exp_p(cur_pan, cur_dual, cur_bus, cur_byp, cur_div);
        int mn = exp_floor(cur_pan, cur_dual, cur_bus);
        int px = cur_px + 1, d = cur_dly + 1, w = cur_pw + 1, l = cur_ln + 1;
        int seg = px + d + w;
        string tg;
        if (cur_byp) tg = (mn == 1) ? "R3" : "R4";
        else tg = (cur_div != 0 && 2 * cur_div >= mn) ? "R2" : "R4";
        chk(m_hs == l * w * p, "R9 hsync cycles", m_hs, l * w * p);
        chk(m_gap == d * p, "R8 porch gap", m_gap, d * p);
        chk(m_den == l * px * p, cur_gated ? "R6 den cycles" : "R7 den cycles", m_den, l * px * p);
        chk(m_launch == l * seg, cur_gated ? "R6 launches" : "R12 launches", m_launch, l * seg);
        chk(m_min == p, {tg, " min launch interval"}, m_min, p);
        if (cur_gated) begin
            chk(m_cyc >= l * seg * p, "R6 gated frame length", m_cyc, l * seg * p);
        end else begin
            chk(m_cyc == l * seg * p, "R11 frame length", m_cyc, l * seg * p);
            chk(m_vs == seg * p, "R10 vsync cycles", m_vs, seg * p);
            chk(m_max == p, "R12 max launch interval", m_max, p);
            chk(m_dhi == l * seg * (p / 2), {tg, " dot_clk high cycles"}, m_dhi, l * seg * (p / 2));
            chk(m_align == m_launch, "R5 launch edge", m_align, m_launch);
        end
    endtask

    task automatic step(input int pan, dual, bus, byp, div, rise, gated, px, dly, pw, ln);
        apply(pan, dual, bus, byp, div, rise, gated, px, dly, pw, ln);
        measure();
        check_frame();
        cur_pan = pan; cur_dual = dual; cur_bus = bus; cur_byp = byp; cur_div = div;
        cur_rise = rise; cur_gated = gated; cur_px = px; cur_dly = dly; cur_pw = pw; cur_ln = ln;
    endtask

    initial begin
        int i;
        int seen;
        apply(0, 0, 0, 0, 2, 0, 0, 2, 1, 0, 1);
        cur_pan = 0; cur_dual = 0; cur_bus = 0; cur_byp = 0; cur_div = 2;
        cur_rise = 0; cur_gated = 0; cur_px = 2; cur_dly = 1; cur_pw = 0; cur_ln = 1;
        repeat (4) sample_step();
        chk(dot_clk == 0, "R1 dot_clk in reset", dot_clk, 0);
        chk(launch == 0, "R1 launch in reset", launch, 0);
        chk(den == 0, "R1 den in reset", den, 0);
        chk(hsync == 0, "R1 hsync in reset", hsync, 0);
        chk(vsync == 0, "R1 vsync in reset", vsync, 0);
        rst_n = 1'b1;
        wait_rise();

        // Sweep of panel, scan, bus, bypass and divider settings.
        i = 0;
        for (int pan = 0; pan < 3; pan++)
            for (int dual = 0; dual < 2; dual++)
                for (int bus = 0; bus < 3; bus++)
                    for (int byp = 0; byp < 2; byp++)
                        for (int dv = 0; dv < 4; dv++) begin
                            int div = (dv == 0) ? 0 : (dv == 1) ? 1 : (dv == 2) ? 3 : 9;
                            step(pan, dual, bus, byp, div, (i / 2) % 2, 0,
                                 i % 4, i % 3, (i / 3) % 2, 1 + (i % 2));
                            i++;
                        end

        // Gated mode with a random availability pattern.
        for (int g = 0; g < 6; g++)
            step(g % 3, g % 2, (g + 1) % 3, 0, 1 + g, g % 2, 1, 1 + g % 3, g % 2, g % 3, 1 + g % 3);
        step(0, 0, 0, 0, 2, 0, 0, 1, 0, 0, 1);

        // Held-off availability freezes the clock in the pixel segment.
        apply(0, 0, 0, 0, 2, 0, 1, 3, 0, 0, 1);
        wait_rise();
        wait_rise();
        avail_rand = 0;
        pix_avail = 1'b0;
        repeat (40) sample_step();
        seen = 0;
        for (int k = 0; k < 50; k++) begin
            if (launch || dot_clk || den || hsync) seen++;
            sample_step();
        end
        chk(seen == 0, "R6 outputs quiet while starts refused", seen, 0);
        pix_avail = 1'b1;
        seen = 0;
        for (int k = 0; k < 10; k++) begin
            sample_step();
            if (launch && den) seen = 1;
        end
        chk(seen == 1, "R6 restart after data returns", seen, 1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
            $finish;
        end
    end
endmodule